// File: doc/BRIEF.md
# Multi-Lane Serial Flash Master

This block is a serial master for flash-style slaves. It runs transactions that move a byte stream over one, two or four data lanes. Each transaction opens with an 8-bit command. The command always goes out on a single lane while the link is full-duplex. A data phase of a host-given byte count follows, in the lane width the host picked when it started the transaction. In one-lane mode the data phase stays full-duplex: every byte written is also a byte read. In two-lane and four-lane mode the data phase is half-duplex. The host picks write, where the master drives every active lane, or read, where the master releases every lane and samples it.

The host raises a start strobe for one cycle. Along with it the host gives a lane mode, a read flag, a slave index, the command, a byte count and an even clock divisor. The master pulls a transmit byte whenever it needs one. It signals this with a pop pulse, after which the host presents the next byte. Each assembled receive byte comes with a one-cycle valid pulse. A busy level covers the whole transaction, including the idle gap after it. A done pulse marks its end.

The serial clock follows mode 0. It idles low, data changes on its falling edge and data is sampled on its rising edge. The four lanes each have an output and an output enable, and each has a separate input.

Top module: `qspi_master`

## Requirements
- R1: The command byte is sent MSB first on lane 0 (`io_o[0]`) over 8 serial clock cycles, with `io_oe_o` = 4'b0001, whatever mode is chosen for the data phase.
- R2: With `mode_i` = 0 (one lane) the data phase is full-duplex. Each byte taken from `tx_data_i` is sent MSB first on lane 0, and a receive byte is assembled MSB first from lane 1 (`io_i[1]`). One `rx_valid_o` pulse is raised per byte, and `rd_i` has no effect.
- R3: With `mode_i` = 1 (two lanes) each byte takes 4 serial clock cycles, with lane 1 carrying the higher bit of each pair. A write drives `io_oe_o` = 4'b0011 and gives no receive bytes.
- R4: With `mode_i` = 2 or 3 (four lanes) each byte takes 2 serial clock cycles, with lane 3 carrying the highest bit of each nibble. A write drives `io_oe_o` = 4'b1111.
- R5: A two-lane or four-lane read holds `io_oe_o` = 0 for the whole data phase. The lanes are released at least half a serial clock period before the first data sampling edge, and each byte is assembled MSB first.
- R6: `sclk_o` is low whenever no select is asserted. The lane outputs never change while `sclk_o` is high.
- R7: One serial clock period lasts `div_i` system clocks (an even value of at least 2).
- R8: Only `cs_n_o[sel_i]` goes low during a transaction, and it stays low from the first command bit to the last data bit. All selects are high after reset.
- R9: `done_o` pulses for one cycle, exactly one system clock after the select returns high. `busy_o` then stays high for at least one serial clock period with every select high.
- R10: A byte count of zero gives a transaction with only the 8 command cycles. It pops no transmit byte and gives no receive byte.
- R11: A start strobe raised while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a transaction when idle |
| mode_i | input | 2 | Data lane mode: 0 one lane, 1 two lanes, 2/3 four lanes |
| rd_i | input | 1 | Data phase is a read (two/four lanes only) |
| sel_i | input | CS_W | Slave index |
| cmd_i | input | 8 | Command byte |
| len_i | input | LEN_W | Data phase byte count |
| div_i | input | DIV_W | System clocks per serial clock period |
| tx_data_i | input | 8 | Next transmit byte |
| tx_pop_o | output | 1 | Transmit byte taken; present the next |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | `rx_data_o` holds a new byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | NUM_CS | Active-low slave selects |
| io_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables |
| io_i | input | 4 | Lane input values |

## Verification
The bench plays the slave. It captures every lane on each rising serial clock edge and drives reply bits that depend on the edge index. Bit order and lane order within each byte are therefore checked directly. A design that swaps lanes or sends the LSB first returns scrambled bytes. The read turnaround is measured from the enable release to the first data sampling edge, which catches a master that samples while it still drives. The zero-length case, the one-lane mode with the read flag set, the exact done delay and a start strobe during a transaction are all probed. These catch a stray data byte, a wrong duplex mode, a late or missing done pulse, and a second transaction that restarts the select.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    typedef enum logic [1:0] {
        LANE1 = 2'd0,
        LANE2 = 2'd1,
        LANE4 = 2'd2
    } lane_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_TURN,
        ST_DATA,
        ST_GAP
    } state_t;

    function automatic lane_t lane_of(input logic [1:0] m);
        case (m)
            2'd0:    return LANE1;
            2'd1:    return LANE2;
            default: return LANE4;
        endcase
    endfunction

    function automatic logic [3:0] lane_oe(input lane_t w);
        case (w)
            LANE2:   return 4'b0011;
            LANE4:   return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

endpackage

// File: rtl/qspi_clkgen.sv
module qspi_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] half;

    always_comb begin
        half = {1'b0, div_i[DIV_W-1:1]};
        if (half == '0) begin
            half = DIV_W'(1);
        end
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q >= half - DIV_W'(1)) begin
            cnt_d  = '0;
            tick_o = 1'b1;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/qspi_lanes.sv
module qspi_lanes
    import qspi_pkg::*;
(
    input  lane_t       width_i,
    input  logic [7:0]  sh_i,
    input  logic [7:0]  rx_i,
    input  logic [3:0]  io_i,
    output logic [3:0]  io_o,
    output logic [7:0]  sh_next_o,
    output logic [7:0]  rx_next_o,
    output logic [2:0]  cyc_last_o
);
    always_comb begin
        case (width_i)
            LANE2: begin
                io_o       = {2'b00, sh_i[7:6]};
                sh_next_o  = {sh_i[5:0], 2'b00};
                rx_next_o  = {rx_i[5:0], io_i[1:0]};
                cyc_last_o = 3'd3;
            end
            LANE4: begin
                io_o       = sh_i[7:4];
                sh_next_o  = {sh_i[3:0], 4'b0000};
                rx_next_o  = {rx_i[3:0], io_i[3:0]};
                cyc_last_o = 3'd1;
            end
            default: begin
                io_o       = {3'b000, sh_i[7]};
                sh_next_o  = {sh_i[6:0], 1'b0};
                rx_next_o  = {rx_i[6:0], io_i[1]};
                cyc_last_o = 3'd7;
            end
        endcase
    end
endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int LEN_W  = 8,
    parameter int DIV_W  = 8,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic              rd_i,
    input  logic [CS_W-1:0]   sel_i,
    input  logic [7:0]        cmd_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [7:0]        tx_data_i,
    output logic              tx_pop_o,
    output logic [7:0]        rx_data_o,
    output logic              rx_valid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              sclk_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic [3:0]        io_o,
    output logic [3:0]        io_oe_o,
    input  logic [3:0]        io_i
);
    typedef struct packed {
        state_t             state;
        logic               sclk;
        logic [NUM_CS-1:0]  cs_n;
        logic [7:0]         sh;
        logic [7:0]         rx;
        logic [2:0]         cyc;
        logic [LEN_W-1:0]   left;
        logic [3:0]         oe;
        lane_t              mode;
        logic               rd;
        logic [DIV_W-1:0]   div;
        logic               gap;
        logic               done_pend;
        logic               done;
        logic               rx_valid;
        logic               tx_pop;
    } regs_t;

    regs_t st_d, st_q;

    logic       tick;
    lane_t      cur_w;
    logic [7:0] sh_next;
    logic [7:0] rx_next;
    logic [2:0] cyc_last;
    logic       write_phase;
    logic       rx_phase;
    logic       finish;

    qspi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.state != ST_IDLE),
        .div_i  (st_q.div),
        .tick_o (tick)
    );

    assign cur_w = (st_q.state == ST_DATA) ? st_q.mode : LANE1;

    qspi_lanes u_lanes (
        .width_i    (cur_w),
        .sh_i       (st_q.sh),
        .rx_i       (st_q.rx),
        .io_i       (io_i),
        .io_o       (io_o),
        .sh_next_o  (sh_next),
        .rx_next_o  (rx_next),
        .cyc_last_o (cyc_last)
    );

    assign write_phase = (st_q.mode == LANE1) || !st_q.rd;
    assign rx_phase    = (st_q.mode == LANE1) || st_q.rd;

    always_comb begin
        st_d           = st_q;
        st_d.done      = st_q.done_pend;
        st_d.done_pend = 1'b0;
        st_d.rx_valid  = 1'b0;
        st_d.tx_pop    = 1'b0;
        finish         = 1'b0;

        case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.state = ST_CMD;
                    st_d.cs_n  = ~(NUM_CS'(1) << sel_i);
                    st_d.sh    = cmd_i;
                    st_d.oe    = 4'b0001;
                    st_d.cyc   = '0;
                    st_d.left  = len_i;
                    st_d.mode  = lane_of(mode_i);
                    st_d.rd    = rd_i;
                    st_d.div   = div_i;
                    st_d.sclk  = 1'b0;
                end
            end
            ST_CMD, ST_DATA: begin
                if (tick) begin
                    if (!st_q.sclk) begin
                        // rising edge: sample
                        st_d.sclk = 1'b1;
                        if (st_q.state == ST_DATA) begin
                            st_d.rx       = rx_next;
                            st_d.rx_valid = (st_q.cyc == cyc_last) && rx_phase;
                        end
                    end else begin
                        // falling edge: launch
                        st_d.sclk = 1'b0;
                        if (st_q.cyc != cyc_last) begin
                            st_d.sh  = sh_next;
                            st_d.cyc = st_q.cyc + 3'd1;
                        end else begin
                            st_d.cyc = '0;
                            if (st_q.state == ST_CMD) begin
                                if (st_q.left == '0) begin
                                    finish = 1'b1;
                                end else if (write_phase) begin
                                    st_d.sh     = tx_data_i;
                                    st_d.tx_pop = 1'b1;
                                    st_d.oe     = lane_oe(st_q.mode);
                                    st_d.state  = ST_DATA;
                                end else begin
                                    st_d.oe    = 4'b0000;
                                    st_d.state = ST_TURN;
                                end
                            end else begin
                                st_d.left = st_q.left - LEN_W'(1);
                                if (st_q.left == LEN_W'(1)) begin
                                    finish = 1'b1;
                                end else if (write_phase) begin
                                    st_d.sh     = tx_data_i;
                                    st_d.tx_pop = 1'b1;
                                end
                            end
                        end
                    end
                end
            end
            ST_TURN: begin
                if (tick) begin
                    st_d.state = ST_DATA;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (st_q.gap) begin
                        st_d.state = ST_IDLE;
                    end else begin
                        st_d.gap = 1'b1;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase

        if (finish) begin
            st_d.state     = ST_GAP;
            st_d.cs_n      = '1;
            st_d.oe        = 4'b0000;
            st_d.gap       = 1'b0;
            st_d.done_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.state     <= ST_IDLE;
            st_q.cs_n      <= '1;
            st_q.mode      <= LANE1;
            st_q.div       <= DIV_W'(2);
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_pop_o   = st_q.tx_pop;
    assign rx_data_o  = st_q.rx;
    assign rx_valid_o = st_q.rx_valid;
    assign busy_o     = (st_q.state != ST_IDLE);
    assign done_o     = st_q.done;
    assign sclk_o     = st_q.sclk;
    assign cs_n_o     = st_q.cs_n;
    assign io_oe_o    = st_q.oe;
endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              sclk_o,
    input logic [NUM_CS-1:0] cs_n_o,
    input logic [3:0]        io_o,
    input logic [3:0]        io_oe_o
);
    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R8
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (&cs_n_o));

    // R8
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n_o) |=> ($stable(cs_n_o) || (&cs_n_o)));

    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n_o) |-> !sclk_o);

    // R6
    launch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(io_o));

    // R9
    done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&cs_n_o) |=> done_o);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    oe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe_o == 4'b0000) || (io_oe_o == 4'b0001) ||
        (io_oe_o == 4'b0011) || (io_oe_o == 4'b1111));
endmodule

bind qspi_master qspi_master_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sclk_o  (sclk_o),
    .cs_n_o  (cs_n_o),
    .io_o    (io_o),
    .io_oe_o (io_oe_o)
);

// File: tb/tb_qspi_master.sv
`timescale 1ns/1ps
module tb_qspi_master;
    localparam int NUM_CS = 2;
    localparam int LEN_W  = 8;
    localparam int DIV_W  = 8;
    localparam int NVEC   = 8;

    // {mode[1:0], rd, sel, len[7:0], div[7:0], cmd[7:0]}
    localparam logic [27:0] VEC [0:NVEC-1] = '{
        {2'd0, 1'b0, 1'b0, 8'd3, 8'd4, 8'h9F},
        {2'd0, 1'b1, 1'b1, 8'd2, 8'd2, 8'h03},
        {2'd1, 1'b0, 1'b0, 8'd4, 8'd2, 8'h3B},
        {2'd1, 1'b1, 1'b1, 8'd3, 8'd6, 8'hBB},
        {2'd2, 1'b0, 1'b0, 8'd5, 8'd4, 8'h32},
        {2'd2, 1'b1, 1'b1, 8'd6, 8'd2, 8'h6B},
        {2'd2, 1'b1, 1'b0, 8'd0, 8'd4, 8'h06},
        {2'd3, 1'b0, 1'b1, 8'd2, 8'd8, 8'hEB}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [1:0]        mode_i = '0;
    logic              rd_i = 1'b0;
    logic [0:0]        sel_i = '0;
    logic [7:0]        cmd_i = '0;
    logic [LEN_W-1:0]  len_i = '0;
    logic [DIV_W-1:0]  div_i = 8'd2;
    logic [7:0]        tx_data_i;
    logic              tx_pop_o;
    logic [7:0]        rx_data_o;
    logic              rx_valid_o;
    logic              busy_o;
    logic              done_o;
    logic              sclk_o;
    logic [NUM_CS-1:0] cs_n_o;
    logic [3:0]        io_o;
    logic [3:0]        io_oe_o;
    logic [3:0]        io_i = '0;

    qspi_master #(.NUM_CS(NUM_CS), .LEN_W(LEN_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .rd_i(rd_i), .sel_i(sel_i), .cmd_i(cmd_i), .len_i(len_i),
        .div_i(div_i), .tx_data_i(tx_data_i), .tx_pop_o(tx_pop_o),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .busy_o(busy_o),
        .done_o(done_o), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .io_o(io_o),
        .io_oe_o(io_oe_o), .io_i(io_i)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] txpat(input int i);
        return 8'(8'hC3 + i * 37);
    endfunction

    function automatic logic [7:0] resp(input int i);
        return 8'(8'h5A ^ 8'(i * 41));
    endfunction

    // current transaction settings, written by the stimulus only
    int          cur_w = 1;
    logic [3:0]  exp_oe = 4'b0001;
    logic [1:0]  exp_cs = 2'b10;

    function automatic logic [3:0] slave_drive(input int k, input int w);
        int j, bpb, b, p, s;
        logic [7:0] v;
        if (k < 8) return 4'b0010;
        j   = k - 8;
        bpb = 8 / w;
        b   = j / bpb;
        p   = j % bpb;
        s   = 8 - w * (p + 1);
        v   = resp(b) >> s;
        if (w == 1) return {2'b00, v[0], 1'b0};
        if (w == 2) return {2'b00, v[1:0]};
        return v[3:0];
    endfunction

    // monitor / slave model
    int         cyc_cnt = 0;
    logic       prev_sclk = 1'b0;
    logic       prev_allhi = 1'b1;
    logic       prev_busy = 1'b0;
    logic [3:0] prev_oe = '0;
    int         rise_k = 0;
    logic [7:0] cmd_cap = '0;
    logic [7:0] dcap [0:15];
    int         oe_err = 0;
    int         rise0_cyc = 0, rise1_cyc = 0;
    int         cs_rise_cyc = 0, done_cyc = 0, busy_fall_cyc = 0;
    int         done_cnt = 0;
    int         rx_n = 0;
    logic [7:0] rxb [0:15];
    int         tx_idx = 0;
    int         cs_fall_cnt = 0;
    int         oe_off_cyc = -1;
    int         first_data_rise_cyc = -1;
    int         idle_sclk_err = 0;
    int         cs_bad = 0;

    assign tx_data_i = txpat(tx_idx);

    always @(negedge clk) begin
        logic allhi;
        cyc_cnt++;
        allhi = &cs_n_o;
        if (rst_n) begin
            if (prev_allhi && !allhi) begin
                cs_fall_cnt++;
                rise_k = 0;
                cmd_cap = '0;
                for (int i = 0; i < 16; i++) dcap[i] = '0;
                rx_n = 0;
                tx_idx = 0;
                oe_off_cyc = -1;
                first_data_rise_cyc = -1;
                oe_err = 0;
                io_i = slave_drive(0, cur_w);
            end
            if (!allhi && cs_n_o !== exp_cs) cs_bad++;
            if (allhi && sclk_o) idle_sclk_err++;
            if (!allhi && io_oe_o == 4'b0000 && prev_oe != 4'b0000) oe_off_cyc = cyc_cnt;
            if (sclk_o && !prev_sclk) begin
                if (rise_k == 0) rise0_cyc = cyc_cnt;
                if (rise_k == 1) rise1_cyc = cyc_cnt;
                if (rise_k < 8) begin
                    cmd_cap = {cmd_cap[6:0], io_o[0]};
                    if (io_oe_o != 4'b0001) oe_err++;
                end else begin
                    int j, b;
                    j = rise_k - 8;
                    if (j == 0) first_data_rise_cyc = cyc_cnt;
                    b = j / (8 / cur_w);
                    if (io_oe_o != exp_oe) oe_err++;
                    if (b < 16) begin
                        if (cur_w == 1)      dcap[b] = {dcap[b][6:0], io_o[0]};
                        else if (cur_w == 2) dcap[b] = {dcap[b][5:0], io_o[1:0]};
                        else                 dcap[b] = {dcap[b][3:0], io_o[3:0]};
                    end
                end
                rise_k++;
                io_i = slave_drive(rise_k, cur_w);
            end
            if (!prev_allhi && allhi) cs_rise_cyc = cyc_cnt;
            if (done_o) begin
                done_cyc = cyc_cnt;
                done_cnt++;
            end
            if (prev_busy && !busy_o) busy_fall_cyc = cyc_cnt;
            if (rx_valid_o) begin
                if (rx_n < 16) rxb[rx_n] = rx_data_o;
                rx_n++;
            end
            if (tx_pop_o) tx_idx++;
        end
        prev_sclk  = sclk_o;
        prev_allhi = allhi;
        prev_busy  = busy_o;
        prev_oe    = io_oe_o;
    end

    task automatic launch(input logic [27:0] v);
        int m;
        m = int'(v[27:26]);
        cur_w  = (m == 0) ? 1 : ((m == 1) ? 2 : 4);
        exp_cs = v[24] ? 2'b01 : 2'b10;
        if (m != 0 && v[25]) exp_oe = 4'b0000;
        else exp_oe = (cur_w == 1) ? 4'b0001 : ((cur_w == 2) ? 4'b0011 : 4'b1111);
        @(negedge clk);
        mode_i  = v[27:26];
        rd_i    = v[25];
        sel_i   = v[24];
        len_i   = v[23:16];
        div_i   = v[15:8];
        cmd_i   = v[7:0];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle(output bit hung);
        int n;
        n = 0;
        hung = 1'b0;
        while (busy_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) hung = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic verify(input logic [27:0] v, input int done_before);
        int m, len, div, w, exp_rises;
        bit rd, wr;
        string tag;
        m    = int'(v[27:26]);
        rd   = v[25];
        len  = int'(v[23:16]);
        div  = int'(v[15:8]);
        w    = (m == 0) ? 1 : ((m == 1) ? 2 : 4);
        wr   = (m == 0) || !rd;
        tag  = (m == 0) ? "R2" : ((m == 1) ? "R3" : "R4");
        if (!wr) tag = "R5";
        exp_rises = 8 + len * (8 / w);
        // R1 command byte on lane 0
        check(cmd_cap == v[7:0], "R1", "command byte", int'(cmd_cap), int'(v[7:0]));
        // R7 serial clock period
        check(rise1_cyc - rise0_cyc == div, "R7", "sclk period", rise1_cyc - rise0_cyc, div);
        check(rise_k == exp_rises, tag, "sclk rise count", rise_k, exp_rises);
        check(oe_err == 0, tag, "lane enable errors", oe_err, 0);
        if (wr) begin
            check(tx_idx == len, tag, "tx pops", tx_idx, len);
            for (int i = 0; i < len; i++)
                check(dcap[i] == txpat(i), tag, "tx byte on lanes", int'(dcap[i]), int'(txpat(i)));
        end
        if (m == 0 || rd) begin
            check(rx_n == len, tag, "rx byte count", rx_n, len);
            for (int i = 0; i < len && i < 16; i++)
                check(rxb[i] == resp(i), tag, "rx byte", int'(rxb[i]), int'(resp(i)));
        end else begin
            check(rx_n == 0, tag, "no rx in write", rx_n, 0);
        end
        if (!wr && len > 0) begin
            // R5 turnaround gap
            check(first_data_rise_cyc - oe_off_cyc >= div / 2, "R5", "turnaround cycles",
                  first_data_rise_cyc - oe_off_cyc, div / 2);
        end
        if (len == 0) begin
            // R10 command-only transaction
            check(rise_k == 8 && tx_idx == 0 && rx_n == 0, "R10", "zero length rises",
                  rise_k, 8);
        end
        // R9 done timing and gap
        check(done_cnt == done_before + 1, "R9", "done pulses", done_cnt - done_before, 1);
        check(done_cyc - cs_rise_cyc == 1, "R9", "done delay", done_cyc - cs_rise_cyc, 1);
        check(busy_fall_cyc - cs_rise_cyc >= div, "R9", "deselect gap",
              busy_fall_cyc - cs_rise_cyc, div);
        // R8 select line
        check(cs_bad == 0, "R8", "wrong select", cs_bad, 0);
        // R6 idle clock
        check(idle_sclk_err == 0, "R6", "sclk high while deselected", idle_sclk_err, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        bit hung;
        int db, fc;
        repeat (3) @(negedge clk);
        // reset state: R8 R6 R9
        check(cs_n_o == 2'b11, "R8", "reset selects", int'(cs_n_o), 3);
        check(sclk_o == 1'b0, "R6", "reset sclk", int'(sclk_o), 0);
        check(io_oe_o == 4'b0000 && busy_o == 1'b0 && done_o == 1'b0, "R9",
              "reset oe/busy/done", int'({io_oe_o, busy_o, done_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int t = 0; t < NVEC; t++) begin
            db = done_cnt;
            launch(VEC[t]);
            wait_idle(hung);
            check(!hung, "R9", "transaction ended", int'(hung), 0);
            verify(VEC[t], db);
        end

        // R11: start strobe during a transaction is ignored
        begin
            logic [27:0] v;
            v  = {2'd1, 1'b0, 1'b0, 8'd3, 8'd4, 8'hA5};
            db = done_cnt;
            fc = cs_fall_cnt;
            launch(v);
            repeat (10) @(negedge clk);
            mode_i  = 2'd2;
            cmd_i   = 8'h5A;
            len_i   = 8'd1;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            wait_idle(hung);
            verify(v, db);
            repeat (50) @(negedge clk);
            check(cs_fall_cnt == fc + 1, "R11", "extra transaction", cs_fall_cnt - fc, 1);
            check(busy_o == 1'b0, "R11", "busy after ignored start", int'(busy_o), 0);
            check(cmd_cap == 8'hA5, "R11", "command kept", int'(cmd_cap), 8'hA5);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule